// File: doc/BRIEF.md
# Instruction Fetch Execution Monitor

This block sits on the read-data path between memory and a 32-bit CPU. It blocks code execution from two address ranges. The first range is set by software. The second is a fixed firmware-RAM range, set by module parameters. When the CPU fetches an instruction from a blocked address, the block returns the word 32'h0000_0000 in place of the memory data. That word is an illegal instruction, so the CPU traps and halts. Every other access passes through unchanged.

Software sets the user range through a small register-write port:

- Select 0 writes the lowest protected address.
- Select 1 writes the highest protected address.
- Select 2 writes the control register. A write there with bit 0 set switches the monitor on.

Once the monitor is on, the configuration is frozen. Only a reset clears it. The address check is combinational against the current request. A register write takes effect from the clock edge that ends its write cycle.

Top module: `exec_guard`

## Requirements
- R1: After reset the start register, the end register and the enable bit are all zero. With the monitor off, a fetch outside the firmware range returns mem_rdata unchanged, even at address 0.
- R2: While the monitor is off, writes with cfg_sel=0 load the start register and writes with cfg_sel=1 load the end register.
- R3: A write with cfg_sel=2 and cfg_wdata bit 0 = 1 switches the monitor on from the next cycle. A write with cfg_sel=2 and bit 0 = 0 leaves it off.
- R4: With the monitor on, a fetch whose address satisfies start <= addr <= end returns 32'h0000_0000. Both bounds are included.
- R5: With the monitor on, a fetch outside [start, end] and outside the firmware range returns mem_rdata.
- R6: When start > end, the user range protects no address.
- R7: Once the monitor is on, it stays on. Writes to the start, end and control registers have no effect until reset.
- R8: A fetch in [FW_BASE, FW_BASE+FW_SIZE-1] always returns 32'h0000_0000, whether the monitor is on or off. FW_BASE+FW_SIZE is not protected.
- R9: An access with fetch_instr=0 always returns mem_rdata, including accesses to protected addresses.
- R10: Reset clears the lock and the enable bit, and makes the user range unprotected again.
- R11: A fetch in the same cycle as a configuration write is judged against the configuration as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 end, 2 control |
| cfg_wdata | input | 32 | Register write data |
| fetch_addr | input | 32 | CPU request address |
| fetch_instr | input | 1 | High when the request is an instruction fetch |
| mem_rdata | input | 32 | Read data from memory |
| cpu_rdata | output | 32 | Read data delivered to the CPU |

## Verification
A configuration write and a protected-range fetch can occur in the same cycle. Examples are the enabling control write, or an attempted start or end write after lock, each with a fetch to the range. The bench drives both on the same falling edge. It samples cpu_rdata before the next rising edge, where the fetch must still see the old configuration. It then samples again one cycle later, where the new state (or the ignored write) must show.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
    localparam int XW = 32;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [XW-1:0] lo;
        logic [XW-1:0] hi;
        logic          armed;
    } guard_cfg_t;

    localparam logic [XW-1:0] TRAP_WORD = '0;
endpackage

// File: rtl/exmon_cfg.sv
module exmon_cfg
    import exmon_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [XW-1:0] wdata,
    output guard_cfg_t    cfg
);
    guard_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && !cfg_q.armed) begin
            unique case (cfg_sel_e'(sel))
                SEL_LO:   cfg_d.lo = wdata;
                SEL_HI:   cfg_d.hi = wdata;
                SEL_CTRL: cfg_d.armed = wdata[0];
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.armed |=> cfg_q.armed); // R7
    AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.armed |=> $stable(cfg_q.lo)); // R7
    AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.armed |=> $stable(cfg_q.hi)); // R7
endmodule

// File: rtl/exmon_window.sv
module exmon_window
    import exmon_pkg::*;
(
    input  logic          active,
    input  logic [XW-1:0] addr,
    input  logic [XW-1:0] lo,
    input  logic [XW-1:0] hi,
    output logic          hit
);
    logic above_lo, below_hi;

    always_comb begin
        above_lo = (addr >= lo);
        below_hi = (addr <= hi);
        hit      = active && above_lo && below_hi;
    end
endmodule

// File: rtl/exec_guard.sv
module exec_guard
    import exmon_pkg::*;
#(
    parameter logic [31:0] FW_BASE = 32'hD000_0000,
    parameter logic [31:0] FW_SIZE = 32'h0000_0800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] fetch_addr,
    input  logic        fetch_instr,
    input  logic [31:0] mem_rdata,
    output logic [31:0] cpu_rdata
);
    localparam logic [XW-1:0] FW_LAST = FW_BASE + FW_SIZE - 1;

    guard_cfg_t cfg;
    logic       usr_hit, fw_hit, block;

    exmon_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    exmon_window u_usr_win (
        .active (cfg.armed),
        .addr   (fetch_addr),
        .lo     (cfg.lo),
        .hi     (cfg.hi),
        .hit    (usr_hit)
    );

    generate
        if (FW_SIZE != 0) begin : g_fw
            exmon_window u_fw_win (
                .active (1'b1),
                .addr   (fetch_addr),
                .lo     (FW_BASE),
                .hi     (FW_LAST),
                .hit    (fw_hit)
            );
        end else begin : g_no_fw
            assign fw_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        block     = fetch_instr && (usr_hit || fw_hit);
        cpu_rdata = block ? TRAP_WORD : mem_rdata;
    end

    AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_instr |-> cpu_rdata == mem_rdata); // R9
    AST_FW_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_instr && fw_hit) |-> cpu_rdata == TRAP_WORD); // R8
    AST_OFF_NO_USR: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.armed |-> !usr_hit); // R1
    AST_EMPTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.lo > cfg.hi) |-> !usr_hit); // R6
endmodule

// File: tb/exec_guard_bench.sv
module exec_guard_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] FWB = 32'hD000_0000;
    localparam logic [31:0] FWS = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_instr = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] cpu_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_guard #(.FW_BASE(FWB), .FW_SIZE(FWS)) u_exec_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fetch_addr(fetch_addr),
        .fetch_instr(fetch_instr), .mem_rdata(mem_rdata),
        .cpu_rdata(cpu_rdata)
    );

    task automatic check(input string req, input logic [31:0] exp);
        total++;
        if (cpu_rdata !== exp) begin
            bad++;
            $display("FAIL %s: cpu_rdata=%h expected=%h", req, cpu_rdata, exp);
        end
    endtask

    // drive a request on a falling edge and check it before the rising edge
    task automatic probe(input string req, input logic [31:0] a, input logic f,
                         input logic blocked);
        logic [31:0] d;
        @(negedge clk);
        d = a ^ 32'h5A5A_1234;
        fetch_addr = a; fetch_instr = f; mem_rdata = d;
        #1 check(req, blocked ? 32'h0 : d);
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        probe("R1", 32'h0000_0100, 1'b1, 1'b0);
        probe("R1", 32'h0000_0000, 1'b1, 1'b0);
    endtask

    task automatic t_fw();
        probe("R8", FWB, 1'b1, 1'b1);
        probe("R8", FWB + FWS - 1, 1'b1, 1'b1);
        probe("R8", FWB + FWS, 1'b1, 1'b0);
        probe("R9", FWB + 32'h10, 1'b0, 1'b0);
    endtask

    task automatic t_region();
        wr(2'd0, 32'h0000_1000);
        wr(2'd1, 32'h0000_1FFF);
        probe("R2", 32'h0000_1000, 1'b1, 1'b0);
        wr(2'd2, 32'h0);
        probe("R3", 32'h0000_1000, 1'b1, 1'b0);
        // enable write and fetch in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h1;
        fetch_addr = 32'h0000_1000; fetch_instr = 1'b1; mem_rdata = 32'hCAFE_0001;
        #1 check("R11", 32'hCAFE_0001);
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
        #1 check("R3", 32'h0);
        probe("R4", 32'h0000_1000, 1'b1, 1'b1);
        probe("R4", 32'h0000_1FFF, 1'b1, 1'b1);
        probe("R5", 32'h0000_0FFF, 1'b1, 1'b0);
        probe("R5", 32'h0000_2000, 1'b1, 1'b0);
        probe("R9", 32'h0000_1800, 1'b0, 1'b0);
    endtask

    task automatic t_lock();
        // start write in same cycle as a fetch inside the old range
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0000_3000;
        fetch_addr = 32'h0000_1004; fetch_instr = 1'b1; mem_rdata = 32'h1111_2222;
        #1 check("R11", 32'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        wr(2'd1, 32'h0000_3FFF);
        wr(2'd2, 32'h0);
        probe("R7", 32'h0000_1000, 1'b1, 1'b1);
        probe("R7", 32'h0000_3000, 1'b1, 1'b0);
        probe("R7", 32'h0000_1FFF, 1'b1, 1'b1);
    endtask

    task automatic t_after_reset();
        do_reset();
        probe("R10", 32'h0000_1000, 1'b1, 1'b0);
        probe("R8", FWB + 32'h4, 1'b1, 1'b1);
    endtask

    task automatic t_inverted();
        wr(2'd0, 32'h0000_5000);
        wr(2'd1, 32'h0000_4000);
        wr(2'd2, 32'h1);
        probe("R6", 32'h0000_4800, 1'b1, 1'b0);
        probe("R6", 32'h0000_5000, 1'b1, 1'b0);
        probe("R6", 32'h0000_4000, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fw();
        t_region();
        t_lock();
        t_after_reset();
        t_inverted();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule